// File: doc/BRIEF.md
# Bus wake-up pattern detector

This block watches the level of a differential bus, already turned into a single dominant/recessive bit, while the device sits in a low-power mode. It recognises a remote wake-up request: four back-to-back phases, dominant then recessive then dominant then recessive. Each phase must last a programmable minimum number of timebase ticks, and the whole request must finish inside a programmable window.

When a request is recognised, the block latches a wake-source flag for this bus. The interrupt output follows the flag only while interrupt enable is set. The receive-data output is held low for as long as the flag stays set. If the device is in SLEEP, the block also issues a one-cycle request to move to STANDBY. The flag clears when software sets the receiver-enable or transmitter-enable bit, drops the wake-enable bit, or reads the wake-source register.

All durations count cycles on which the slow `tick_en` input is high. The bus level passes through a two-flop synchroniser before any logic uses it.

Top module: `bus_wake_detect`

## Requirements
- R1: `bus_dom_raw` (1 = dominant) passes through two flops. While no wake is pending, `rxd` equals the inverse of the input as it was two clock edges earlier.
- R2: With detection enabled, the phase sequence is dominant, recessive, dominant, recessive. A dominant phase qualifies once it has counted `dom_min_ticks` ticks and a recessive phase once it has counted `rec_min_ticks` ticks. The tick in the cycle a phase is entered is not counted. The last recessive phase completes the pattern as soon as it qualifies, with no need for a further edge.
- R3: A phase that changes level before it qualifies abandons the pattern. If the new level is dominant, it is taken as a fresh first dominant phase.
- R4: The window counter restarts at each entry into the first dominant phase and counts ticks. Once it reaches `window_ticks` before completion, the partial pattern is dropped, and this takes priority over qualification in the same cycle.
- R5: `wake_flag` rises on the clock edge that ends the completing cycle and stays high until a clear condition occurs.
- R6: `wake_irq` is high exactly when `wake_flag` is high and `cfg_int_en` is 1.
- R7: While `wake_flag` is high, `rxd` is 0 whatever the bus level.
- R8: A pulse on `wr_rx_en_set`, `wr_tx_en_set` or `wsrc_rd`, or a low `cfg_wake_en`, clears `wake_flag` at the next edge. A clear wins over a completion in the same cycle.
- R9: While `cfg_wake_en` is 0, no pattern is tracked and none can complete.
- R10: A completion while `in_sleep` is 1 produces a one-cycle `stby_req` pulse, registered together with the flag. A completion with `in_sleep` at 0 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase enable, one count per high cycle |
| bus_dom_raw | input | 1 | Asynchronous bus level, 1 = dominant |
| cfg_wake_en | input | 1 | Wake detection enable |
| cfg_int_en | input | 1 | Interrupt enable |
| wr_rx_en_set | input | 1 | Strobe: receiver-enable bit written to 1 |
| wr_tx_en_set | input | 1 | Strobe: transmitter-enable bit written to 1 |
| wsrc_rd | input | 1 | Strobe: wake-source register read |
| in_sleep | input | 1 | Device mode is SLEEP |
| dom_min_ticks | input | CW | Minimum dominant phase length in ticks |
| rec_min_ticks | input | CW | Minimum recessive phase length in ticks |
| window_ticks | input | WW | Overall pattern window in ticks |
| wake_flag | output | 1 | Wake-source flag for this bus |
| wake_irq | output | 1 | Interrupt request |
| rxd | output | 1 | Receive data, 0 = dominant or wake pending |
| stby_req | output | 1 | One-cycle request to move SLEEP to STANDBY |

## Verification
The bench builds the block with CW = 5 and WW = 7. Minimum phase lengths then run from 0 to 31 ticks and the window from 0 to 127 ticks. With these values, random phase lengths regularly reach the threshold, fall one tick short of it, or overrun the window within a few dozen cycles. The bench also randomises the tick rate and the thresholds, so phase counts saturate at their threshold and the window expires during any of the four phases.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DOM1 = 3'd1,
    PH_REC1 = 3'd2,
    PH_DOM2 = 3'd3,
    PH_REC2 = 3'd4
  } phase_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], din};
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import wake_pkg::*;
#(
  parameter int CW = 16,
  parameter int WW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          bus_dom,
  input  logic [CW-1:0] dom_min,
  input  logic [CW-1:0] rec_min,
  input  logic [WW-1:0] win_max,
  output phase_e        phase,
  output logic          det,
  output logic          expired
);
  phase_e        phase_q, phase_d;
  logic [CW-1:0] pc_q, pc_d, pc_step, thr_cur;
  logic [WW-1:0] wc_q, wc_d, wc_step;
  logic          dom_ok, rec_ok;

  function automatic logic [CW-1:0] ph_bump(input logic [CW-1:0] c,
                                            input logic [CW-1:0] lim,
                                            input logic t);
    return (t && (c < lim)) ? c + 1'b1 : c;
  endfunction

  function automatic logic [WW-1:0] win_bump(input logic [WW-1:0] c,
                                             input logic [WW-1:0] lim,
                                             input logic t);
    return (t && (c < lim)) ? c + 1'b1 : c;
  endfunction

  always_comb begin
    thr_cur = ((phase_q == PH_DOM1) || (phase_q == PH_DOM2)) ? dom_min : rec_min;
    pc_step = ph_bump(pc_q, thr_cur, tick);
    wc_step = win_bump(wc_q, win_max, tick);
    dom_ok  = (pc_q >= dom_min);
    rec_ok  = (pc_q >= rec_min);
    expired = (phase_q != PH_IDLE) && (wc_q >= win_max);
  end

  always_comb begin
    phase_d = phase_q;
    pc_d    = pc_q;
    wc_d    = wc_q;
    det     = 1'b0;
    if (!en || expired) begin
      phase_d = PH_IDLE;
      pc_d    = '0;
      wc_d    = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (bus_dom) begin
            phase_d = PH_DOM1;
            pc_d    = '0;
            wc_d    = '0;
          end
        end
        PH_DOM1, PH_DOM2: begin
          wc_d = wc_step;
          if (!bus_dom) begin
            pc_d = '0;
            if (dom_ok) begin
              phase_d = (phase_q == PH_DOM1) ? PH_REC1 : PH_REC2;
            end else begin
              phase_d = PH_IDLE;
              wc_d    = '0;
            end
          end else begin
            pc_d = pc_step;
          end
        end
        PH_REC1: begin
          wc_d = wc_step;
          if (bus_dom) begin
            pc_d = '0;
            if (rec_ok) begin
              phase_d = PH_DOM2;
            end else begin
              phase_d = PH_DOM1;
              wc_d    = '0;
            end
          end else begin
            pc_d = pc_step;
          end
        end
        PH_REC2: begin
          if (rec_ok) begin
            det     = 1'b1;
            phase_d = PH_IDLE;
            pc_d    = '0;
            wc_d    = '0;
          end else if (bus_dom) begin
            phase_d = PH_DOM1;
            pc_d    = '0;
            wc_d    = '0;
          end else begin
            pc_d = pc_step;
            wc_d = wc_step;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          pc_d    = '0;
          wc_d    = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pc_q    <= '0;
      wc_q    <= '0;
    end else begin
      phase_q <= phase_d;
      pc_q    <= pc_d;
      wc_q    <= wc_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic det,
  input  logic clr,
  input  logic sleep,
  output logic flag,
  output logic stby
);
  logic flag_q, stby_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      stby_q <= 1'b0;
    end else begin
      if (clr)      flag_q <= 1'b0;
      else if (det) flag_q <= 1'b1;
      stby_q <= det & sleep;
    end
  end

  assign flag = flag_q;
  assign stby = stby_q;
endmodule

// File: rtl/bus_wake_detect.sv
module bus_wake_detect
  import wake_pkg::*;
#(
  parameter int CW = 16,
  parameter int WW = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_dom_raw,
  input  logic          cfg_wake_en,
  input  logic          cfg_int_en,
  input  logic          wr_rx_en_set,
  input  logic          wr_tx_en_set,
  input  logic          wsrc_rd,
  input  logic          in_sleep,
  input  logic [CW-1:0] dom_min_ticks,
  input  logic [CW-1:0] rec_min_ticks,
  input  logic [WW-1:0] window_ticks,
  output logic          wake_flag,
  output logic          wake_irq,
  output logic          rxd,
  output logic          stby_req
);
  logic   bus_lvl;
  logic   det_pulse;
  logic   clr_evt;
  logic   win_expired;
  phase_e seq_phase;

  wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (bus_dom_raw),
    .dout (bus_lvl)
  );

  wake_seq #(.CW(CW), .WW(WW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cfg_wake_en),
    .tick   (tick_en),
    .bus_dom(bus_lvl),
    .dom_min(dom_min_ticks),
    .rec_min(rec_min_ticks),
    .win_max(window_ticks),
    .phase  (seq_phase),
    .det    (det_pulse),
    .expired(win_expired)
  );

  assign clr_evt = wr_rx_en_set | wr_tx_en_set | wsrc_rd | ~cfg_wake_en;

  wake_flag_reg u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .det  (det_pulse),
    .clr  (clr_evt),
    .sleep(in_sleep),
    .flag (wake_flag),
    .stby (stby_req)
  );

  assign wake_irq = wake_flag & cfg_int_en;
  assign rxd      = wake_flag ? 1'b0 : ~bus_lvl;
endmodule

// File: rtl/wake_chk.sv
module wake_chk
  import wake_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wake_en,
  input logic       cfg_int_en,
  input logic       in_sleep,
  input logic       wake_flag,
  input logic       wake_irq,
  input logic       rxd,
  input logic       stby_req,
  input logic       det_pulse,
  input logic       clr_evt,
  input logic       win_expired,
  input logic [2:0] seq_phase
);
  a_r7_rxd_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    wake_flag |-> !rxd);

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake_flag) && cfg_int_en) |-> wake_irq);

  a_r8_clear_next: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !wake_flag);

  a_r5_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(det_pulse));

  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wake_en |=> (seq_phase == PH_IDLE));

  a_r10_stby_cause: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |-> $past(det_pulse && in_sleep));

  a_r4_expiry_drops: assert property (@(posedge clk) disable iff (!rst_n)
    win_expired |=> (seq_phase == PH_IDLE));

  a_r2_done_in_last: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> (seq_phase == PH_REC2));
endmodule

bind bus_wake_detect wake_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wake_en(cfg_wake_en),
  .cfg_int_en (cfg_int_en),
  .in_sleep   (in_sleep),
  .wake_flag  (wake_flag),
  .wake_irq   (wake_irq),
  .rxd        (rxd),
  .stby_req   (stby_req),
  .det_pulse  (det_pulse),
  .clr_evt    (clr_evt),
  .win_expired(win_expired),
  .seq_phase  (seq_phase)
);

// File: tb/sim_bus_wake_detect.sv
`timescale 1ns/1ps
module sim_bus_wake_detect;
  localparam int CW = 5;
  localparam int WW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1, bus = 1'b0, wen = 1'b0, ien = 1'b0;
  logic rxw = 1'b0, txw = 1'b0, rd = 1'b0, slp = 1'b0;
  logic [CW-1:0] dmin = 5'd3, rmin = 5'd3;
  logic [WW-1:0] win = 7'd100;
  logic flag, irq, rxd, stby;

  int checks = 0, fails = 0, cyc = 0, stby_cnt = 0;
  bit rnd_tick = 1'b0, cmp_on = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  bus_wake_detect #(.CW(CW), .WW(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_dom_raw(bus),
    .cfg_wake_en(wen), .cfg_int_en(ien), .wr_rx_en_set(rxw),
    .wr_tx_en_set(txw), .wsrc_rd(rd), .in_sleep(slp),
    .dom_min_ticks(dmin), .rec_min_ticks(rmin), .window_ticks(win),
    .wake_flag(flag), .wake_irq(irq), .rxd(rxd), .stby_req(stby)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Reference model: phase index 0 idle, 1..4 = dom, rec, dom, rec
  int m_s1 = 0, m_s2 = 0, m_ph = 0, m_pc = 0, m_wc = 0, m_flag = 0, m_stby = 0;

  function automatic int want_rxd(int f, int lvl);
    return (f != 0) ? 0 : (lvl != 0 ? 0 : 1);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_ph = 0; m_pc = 0; m_wc = 0; m_flag = 0; m_stby = 0;
    end else begin
      int need, t;
      bit en, fin, clr, dph;
      en  = wen;
      t   = tick_en;
      fin = en && m_ph == 4 && m_wc < win && m_pc >= rmin;
      clr = rxw || txw || rd || !en;
      if (clr) m_flag = 0; else if (fin) m_flag = 1;
      m_stby = (fin && slp) ? 1 : 0;
      if (!en || (m_ph != 0 && m_wc >= win)) begin
        m_ph = 0; m_pc = 0; m_wc = 0;
      end else if (m_ph == 0) begin
        if (m_s2 != 0) begin m_ph = 1; m_pc = 0; m_wc = 0; end
      end else if (m_ph == 4 && m_pc >= rmin) begin
        m_ph = 0; m_pc = 0; m_wc = 0;
      end else begin
        dph  = (m_ph == 1 || m_ph == 3);
        need = dph ? dmin : rmin;
        if ((m_s2 != 0) != dph) begin
          if (m_pc >= need) begin
            m_ph++; m_pc = 0;
            if (t != 0 && m_wc < win) m_wc++;
          end else if (m_s2 != 0) begin
            m_ph = 1; m_pc = 0; m_wc = 0;
          end else begin
            m_ph = 0; m_pc = 0; m_wc = 0;
          end
        end else begin
          if (t != 0 && m_pc < need) m_pc++;
          if (t != 0 && m_wc < win) m_wc++;
        end
      end
      m_s2 = m_s1;
      m_s1 = bus;
    end
    #1;
    if (stby) stby_cnt++;
    if (rst_n && cmp_on) begin
      check("R5 flag", flag, m_flag);
      check("R6 irq", irq, (m_flag != 0 && ien) ? 1 : 0);
      check("R7/R1 rxd", rxd, want_rxd(m_flag, m_s2));
      check("R10 stby", stby, m_stby);
    end
  end

  always @(negedge clk) tick_en <= rnd_tick ? ($urandom_range(0, 9) < 7) : 1'b1;

  task automatic hold(bit lvl, int n);
    bus = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic pattern(int d1, int r1, int d2, int r2);
    hold(1, d1); hold(0, r1); hold(1, d2); hold(0, r2);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("reset flag", flag, 0);
    check("reset irq", irq, 0);
    check("reset rxd", rxd, 1);
    check("reset stby", stby, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wen = 1'b1;
    @(negedge clk);

    // R1: two-stage latency on the bus input
    bus = 1'b1; @(negedge clk);
    check("R1 one edge", rxd, 1);
    @(negedge clk);
    check("R1 two edges", rxd, 0);
    hold(0, 12);

    // R2/R5/R7: full pattern sets flag, rxd forced low on recessive bus
    pattern(10, 10, 10, 10);
    check("R2 pattern detected", flag, 1);
    check("R7 rxd low with recessive bus", rxd, 0);
    ien = 1'b1; @(negedge clk);
    check("R6 irq on", irq, 1);
    ien = 1'b0; @(negedge clk);
    check("R6 irq gated", irq, 0);
    pulse(rd);
    check("R8 read clears", flag, 0);

    // R8: other clear sources
    pattern(10, 10, 10, 10);
    pulse(rxw);
    check("R8 rx enable clears", flag, 0);
    pattern(10, 10, 10, 10);
    pulse(txw);
    check("R8 tx enable clears", flag, 0);
    pattern(10, 10, 10, 10);
    check("R8 precondition", flag, 1);
    wen = 1'b0; @(negedge clk); @(negedge clk);
    check("R8 wake disable clears", flag, 0);

    // R9: disabled, pattern ignored
    pattern(10, 10, 10, 10); hold(0, 5);
    check("R9 no detect while disabled", flag, 0);
    wen = 1'b1; hold(0, 5);

    // R3: short first dominant, then only a partial pattern
    pattern(1, 10, 10, 10); hold(0, 10);
    check("R3 short dominant discarded", flag, 0);
    // R3: short recessive restarts at the dominant that ends it
    hold(1, 10); hold(0, 1); pattern(10, 10, 10, 10);
    check("R3 restart on dominant", flag, 1);
    pulse(rd);

    // R4: window too short for the pattern
    win = 7'd20; hold(0, 3);
    pattern(10, 10, 10, 10); hold(0, 5);
    check("R4 window expiry", flag, 0);
    win = 7'd100; hold(0, 3);

    // R10: standby request in sleep only
    stby_cnt = 0; slp = 1'b1;
    pattern(10, 10, 10, 10); hold(0, 3);
    check("R10 stby pulse in sleep", stby_cnt, 1);
    pulse(rd);
    stby_cnt = 0; slp = 1'b0;
    pattern(10, 10, 10, 10); hold(0, 3);
    check("R10 no stby when awake", stby_cnt, 0);
    pulse(rd);

    // Random: thresholds, tick rate, phase lengths, clears
    rnd_tick = 1'b1;
    for (int s = 0; s < 150; s++) begin
      wen = 1'b0; @(negedge clk);
      dmin = CW'($urandom_range(0, 8));
      rmin = CW'($urandom_range(0, 8));
      win  = WW'($urandom_range(8, 127));
      ien  = 1'($urandom_range(0, 1));
      slp  = 1'($urandom_range(0, 1));
      wen  = 1'b1; @(negedge clk);
      for (int p = 0; p < 20; p++) begin
        int thr = (p % 2 == 0) ? int'(dmin) : int'(rmin);
        hold((p % 2) == 0, $urandom_range(1, 2 * thr + 6));
        if ($urandom_range(0, 15) == 0) pulse(rd);
        if ($urandom_range(0, 31) == 0) pulse(txw);
      end
    end
    rnd_tick = 1'b0;
    hold(0, 5);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule